// File: doc/BRIEF.md
# SD Host Block-Data DMA Engine

This block is the bus-master data mover that sits beside the data FIFO of an SD host. Software programs a transfer mode, a 64-bit start address, a block size and a block count, then writes a start bit. The engine then moves `block count x block size` bytes between the FIFO and one contiguous memory region, one beat at a time. A beat is 1, 2, 4 or 8 bytes wide. When the last beat is accepted, the engine raises a single-cycle done pulse.

There are two channels. Channel 0 carries memory-to-card traffic: it reads memory and pushes into the FIFO. Channel 1 carries card-to-memory traffic: it pops the FIFO and writes memory. Each channel has an active-low release bit. Software clears the bit to abort the channel and hold it idle, and sets the bit again to release it.

The engine is built around one state machine with four states:

- `ST_IDLE`: no transfer. An accepted start moves it to `ST_ARM`.
- `ST_ARM`: waits until the FIFO can take or supply a whole beat, then moves to `ST_REQ`.
- `ST_REQ`: holds the memory request until it is granted.
  - A granted write moves to `ST_ARM`, or to `ST_IDLE` on the last beat.
  - A granted read moves to `ST_RESP`.
- `ST_RESP`: waits for read data. It pushes the data into the FIFO, then moves to `ST_ARM`, or to `ST_IDLE` on the last beat.

A cleared release bit for the active channel sends any non-idle state straight to `ST_IDLE`.

Top module: `sdh_dma_engine`

## Requirements
- R1: Mode word (register word 0) decodes as follows.
  - Bits 17:16 give the direction: 0 is memory-to-card (memory reads, FIFO pushes) and 1 is card-to-memory (FIFO pops, memory writes).
  - Bits 5:4 give the beat width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. `mem_size` carries this code.
  - Bit 0 sets the address mode: 1 increments, 0 holds the address fixed.
- R2: The start address is the low word (register word 1) joined with the high word (register word 2). In incrementing mode each beat's address is the previous one plus the beat size; in fixed mode every beat uses the start address.
- R3: The transfer length register is word 3: block size in bits 11:0 and block count in bits 31:16. The engine issues exactly length / beat-size beats.
- R4: Writing 1 to bit 0 of the control register (word 4) starts a transfer. Reading the control register returns bit 0 as 0 and bit 1 as the busy flag.
- R5: A start issued while a transfer is busy is ignored, and the latched mode, address and length are kept.
- R6: A start is ignored, leaving the engine idle, in any of these cases:
  - the address is not aligned to the beat size;
  - the length is zero or not a multiple of the beat size;
  - the direction code is 2 or 3;
  - the selected channel is held in reset.
- R7: In card-to-memory mode a memory write is requested only while `fifo_level` is at least the beat size. The write data is `fifo_rdata`, and `fifo_pop` pulses exactly when the write is granted.
- R8: In memory-to-card mode a memory read is requested only while `fifo_space` is at least the beat size. Each `mem_rvalid` produces one `fifo_push` carrying the read data.
- R9: For beats narrower than 8 bytes, data sits in the low bytes of `mem_wdata` and `fifo_wdata`, and the upper bytes are zero.
- R10: `dma_done` is high for exactly one cycle: the cycle after the final beat is accepted (write grant or read data). Busy reads 0 in that same cycle.
- R11: The channel reset register is word 5. Bit 8 is channel 0 (memory-to-card) and bit 9 is channel 1 (card-to-memory); both reset to 1. Clearing the active channel's bit aborts the transfer: busy drops on the next cycle, no done pulse is raised, and no further requests are made.
- R12: After reset the engine is idle, `mem_req` and `dma_done` are low, and the mode, control and channel-reset registers read 0, 0 and 0x300.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| dma_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| fifo_level | input | LVL_W | Bytes available in the FIFO (card-to-memory) |
| fifo_space | input | LVL_W | Bytes free in the FIFO (memory-to-card) |
| fifo_rdata | input | 64 | FIFO head data, show-ahead |
| fifo_pop | output | 1 | Remove one beat from the FIFO |
| fifo_push | output | 1 | Write one beat into the FIFO |
| fifo_wdata | output | 64 | Data written into the FIFO |

## Verification
The bench starts transfers while the FIFO is one beat short, in each direction, and then tops it up. A design that ignored the FIFO gate would request memory early, underflowing or overflowing the FIFO.

It issues a second start with a different mode while a transfer waits. It also starts with misaligned, zero-length, non-multiple and reserved-direction settings. A design that re-latched configuration while busy, or accepted bad settings, would emit the wrong beat count, width or addresses.

It clears a channel's release bit mid-transfer and checks that busy drops with no done pulse. It also checks that a start on the held channel is refused.

Fixed-address byte beats and narrow reads check address stepping and masking of the upper bytes. The done pulse is timed against the final grant or read-data cycle, which catches an off-by-one completion.

// File: rtl/sdh_dma_pkg.sv
`timescale 1ns/1ps
package sdh_dma_pkg;

    localparam int MEM_DATA_W = 64;  // widest beat the mode encoding allows

    // register word indices
    localparam logic [2:0] REG_MODE    = 3'd0;
    localparam logic [2:0] REG_ADDR_LO = 3'd1;
    localparam logic [2:0] REG_ADDR_HI = 3'd2;
    localparam logic [2:0] REG_LEN     = 3'd3;
    localparam logic [2:0] REG_CTRL    = 3'd4;
    localparam logic [2:0] REG_CHRST   = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_REQ,
        ST_RESP
    } dma_state_e;

    typedef struct packed {
        logic [1:0] dir;    // 0 memory->card, 1 card->memory
        logic [1:0] width;  // log2 of beat bytes
        logic       inc;    // 1 increment address per beat
    } dma_mode_t;

    function automatic logic [MEM_DATA_W-1:0] beat_mask(input logic [1:0] w);
        logic [MEM_DATA_W-1:0] m;
        unique case (w)
            2'd0:    m = MEM_DATA_W'(64'h0000_0000_0000_00FF);
            2'd1:    m = MEM_DATA_W'(64'h0000_0000_0000_FFFF);
            2'd2:    m = MEM_DATA_W'(64'h0000_0000_FFFF_FFFF);
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sdh_dma_regs.sv
`timescale 1ns/1ps
module sdh_dma_regs
    import sdh_dma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SZ_W   = 12,
    parameter int CNT_W  = 16,
    localparam int HI_W  = ADDR_W - 32,
    localparam int LEN_W = SZ_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              busy,
    output dma_mode_t         mode,
    output logic [ADDR_W-1:0] base_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              start_pulse,
    output logic [1:0]        chan_rel
);
    localparam int CNT_LSB = 16;

    dma_mode_t        mode_q;
    logic [31:0]      addr_lo_q;
    logic [HI_W-1:0]  addr_hi_q;
    logic [SZ_W-1:0]  blk_size_q;
    logic [CNT_W-1:0] blk_cnt_q;
    logic [1:0]       chrst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= '0;
            addr_lo_q  <= '0;
            addr_hi_q  <= '0;
            blk_size_q <= '0;
            blk_cnt_q  <= '0;
            chrst_q    <= 2'b11;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                REG_MODE: begin
                    mode_q.dir   <= cfg_wdata[17:16];
                    mode_q.width <= cfg_wdata[5:4];
                    mode_q.inc   <= cfg_wdata[0];
                end
                REG_ADDR_LO: addr_lo_q <= cfg_wdata;
                REG_ADDR_HI: addr_hi_q <= cfg_wdata[HI_W-1:0];
                REG_LEN: begin
                    blk_size_q <= cfg_wdata[SZ_W-1:0];
                    blk_cnt_q  <= cfg_wdata[CNT_LSB +: CNT_W];
                end
                REG_CHRST: chrst_q <= cfg_wdata[9:8];
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            REG_MODE: begin
                cfg_rdata[17:16] = mode_q.dir;
                cfg_rdata[5:4]   = mode_q.width;
                cfg_rdata[0]     = mode_q.inc;
            end
            REG_ADDR_LO: cfg_rdata = addr_lo_q;
            REG_ADDR_HI: cfg_rdata[HI_W-1:0] = addr_hi_q;
            REG_LEN: begin
                cfg_rdata[SZ_W-1:0]          = blk_size_q;
                cfg_rdata[CNT_LSB +: CNT_W]  = blk_cnt_q;
            end
            REG_CTRL:  cfg_rdata[1]   = busy;  // bit 0 always reads 0
            REG_CHRST: cfg_rdata[9:8] = chrst_q;
            default: ;
        endcase
    end

    assign mode        = mode_q;
    assign base_addr   = {addr_hi_q, addr_lo_q};
    assign xfer_len    = LEN_W'(blk_size_q) * LEN_W'(blk_cnt_q);
    assign start_pulse = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[0];
    assign chan_rel    = chrst_q;

    // R11: channel release bits change only through a register write
    assert_rel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(chrst_q));

endmodule

// File: rtl/sdh_dma_fsm.sv
`timescale 1ns/1ps
module sdh_dma_fsm
    import sdh_dma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 28,
    parameter int LVL_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_pulse,
    input  dma_mode_t             mode,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic [LEN_W-1:0]      xfer_len,
    input  logic [1:0]            chan_rel,
    input  logic [LVL_W-1:0]      fifo_level,
    input  logic [LVL_W-1:0]      fifo_space,
    input  logic [MEM_DATA_W-1:0] fifo_rdata,
    input  logic                  mem_gnt,
    input  logic                  mem_rvalid,
    input  logic [MEM_DATA_W-1:0] mem_rdata,
    output logic                  busy,
    output logic                  done,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [1:0]            mem_size,
    output logic [MEM_DATA_W-1:0] mem_wdata,
    output logic                  fifo_pop,
    output logic                  fifo_push,
    output logic [MEM_DATA_W-1:0] fifo_wdata
);
    dma_state_e        state_q, state_d;
    logic              dir_q;      // 1 = card to memory
    logic [1:0]        width_q;
    logic              inc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic              done_q;

    logic [3:0] beat_bytes, start_beat;
    logic [2:0] align_mask;
    logic       start_ok, abort, fifo_ok, accept, last;

    assign beat_bytes = 4'd1 << width_q;
    assign start_beat = 4'd1 << mode.width;
    assign align_mask = 3'(start_beat - 4'd1);

    always_comb begin
        start_ok = start_pulse && (state_q == ST_IDLE)
                && !mode.dir[1] && chan_rel[mode.dir[0]]
                && (xfer_len != '0)
                && ((xfer_len[2:0] & align_mask) == 3'd0)
                && ((base_addr[2:0] & align_mask) == 3'd0);
    end

    assign abort   = (state_q != ST_IDLE) && !chan_rel[dir_q];
    assign fifo_ok = dir_q ? (fifo_level >= LVL_W'(beat_bytes))
                           : (fifo_space >= LVL_W'(beat_bytes));
    assign accept  = ((state_q == ST_REQ) && mem_gnt && dir_q)
                  || ((state_q == ST_RESP) && mem_rvalid);
    assign last    = (remain_q == LEN_W'(beat_bytes));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok) state_d = ST_ARM;
            ST_ARM:  if (fifo_ok)  state_d = ST_REQ;
            ST_REQ:  if (mem_gnt)  state_d = dir_q ? (last ? ST_IDLE : ST_ARM) : ST_RESP;
            ST_RESP: if (mem_rvalid) state_d = last ? ST_IDLE : ST_ARM;
            default: state_d = ST_IDLE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= 1'b0;
            width_q  <= 2'd0;
            inc_q    <= 1'b0;
            addr_q   <= '0;
            remain_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= accept && last && !abort;
            if (start_ok) begin
                dir_q    <= mode.dir[0];
                width_q  <= mode.width;
                inc_q    <= mode.inc;
                addr_q   <= base_addr;
                remain_q <= xfer_len;
            end else begin
                if ((state_q == ST_REQ) && mem_gnt && inc_q)
                    addr_q <= addr_q + ADDR_W'(beat_bytes);
                if (accept)
                    remain_q <= remain_q - LEN_W'(beat_bytes);
            end
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = done_q;
        mem_req    = (state_q == ST_REQ);
        mem_we     = dir_q;
        mem_addr   = addr_q;
        mem_size   = width_q;
        mem_wdata  = fifo_rdata & beat_mask(width_q);
        fifo_pop   = (state_q == ST_REQ) && mem_gnt && dir_q;
        fifo_push  = (state_q == ST_RESP) && mem_rvalid;
        fifo_wdata = mem_rdata & beat_mask(width_q);
    end

    // R7: a write is only requested with a whole beat in the FIFO
    assert_wr_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (fifo_level >= LVL_W'(beat_bytes)));
    // R8: a read is only requested with room for a whole beat
    assert_rd_has_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (fifo_space >= LVL_W'(beat_bytes)));
    // R2: address holds while a request waits for grant
    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> $stable(mem_addr));
    // R10: done is a single-cycle pulse and coincides with idle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R4: busy only rises after a start request
    assert_busy_from_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_pulse));
    // R11: releasing bit cleared for active channel ends the transfer
    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !chan_rel[dir_q]) |=> (!busy && !done));

endmodule

// File: rtl/sdh_dma_engine.sv
`timescale 1ns/1ps
module sdh_dma_engine
    import sdh_dma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SZ_W   = 12,
    parameter int CNT_W  = 16,
    parameter int LVL_W  = 8,
    localparam int LEN_W = SZ_W + CNT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    output logic                  dma_done,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [1:0]            mem_size,
    output logic [MEM_DATA_W-1:0] mem_wdata,
    input  logic                  mem_gnt,
    input  logic                  mem_rvalid,
    input  logic [MEM_DATA_W-1:0] mem_rdata,
    input  logic [LVL_W-1:0]      fifo_level,
    input  logic [LVL_W-1:0]      fifo_space,
    input  logic [MEM_DATA_W-1:0] fifo_rdata,
    output logic                  fifo_pop,
    output logic                  fifo_push,
    output logic [MEM_DATA_W-1:0] fifo_wdata
);
    dma_mode_t         mode;
    logic [ADDR_W-1:0] base_addr;
    logic [LEN_W-1:0]  xfer_len;
    logic              start_pulse;
    logic [1:0]        chan_rel;
    logic              busy;

    sdh_dma_regs #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .busy(busy),
        .mode(mode), .base_addr(base_addr), .xfer_len(xfer_len),
        .start_pulse(start_pulse), .chan_rel(chan_rel)
    );

    sdh_dma_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LVL_W(LVL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_pulse(start_pulse), .mode(mode), .base_addr(base_addr),
        .xfer_len(xfer_len), .chan_rel(chan_rel),
        .fifo_level(fifo_level), .fifo_space(fifo_space), .fifo_rdata(fifo_rdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(dma_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata),
        .fifo_pop(fifo_pop), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata)
    );

endmodule

// File: tb/sdh_dma_engine_test.sv
`timescale 1ns/1ps
module sdh_dma_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd4;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dma_done, mem_req, mem_we, fifo_pop, fifo_push;
    logic [63:0] mem_addr, mem_wdata, fifo_wdata;
    logic [1:0]  mem_size;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0, fifo_rdata = '0;
    logic [7:0]  fifo_level = '0, fifo_space = '0;

    always #2.5 clk = ~clk;

    sdh_dma_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dma_done(dma_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .fifo_level(fifo_level), .fifo_space(fifo_space), .fifo_rdata(fifo_rdata),
        .fifo_pop(fifo_pop), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    // environment model state
    int fifo_lvl = 0, space_lvl = 0, fifo_idx = 0, beat_b = 8;
    bit gnt_en = 1, pop_pend = 0, rd_pend = 0;
    logic [63:0] rd_addr_p;
    int cyc = 0, wr_n = 0, rd_n = 0, push_n = 0, req_n = 0, done_n = 0;
    int done_cyc = -1, last_acc = -1, pop_bad = 0;
    logic [63:0] wr_addr_l [64];
    logic [63:0] wr_data_l [64];
    logic [1:0]  wr_size_l [64];
    logic [63:0] rd_addr_l [64];
    logic [63:0] push_l    [64];

    function automatic logic [63:0] fifo_pat(input int i);
        return {32'hC0DE_0000 | 32'(i), 32'h5EED_0000 | 32'(i)};
    endfunction
    function automatic logic [63:0] mem_pat(input logic [63:0] a);
        return {a[31:0] ^ 32'hA5A5_0000, ~a[31:0]};
    endfunction
    function automatic logic [63:0] lowmask(input int bytes);
        return (bytes >= 8) ? '1 : ((64'd1 << (bytes * 8)) - 64'd1);
    endfunction

    // memory and FIFO responder
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (pop_pend) begin fifo_idx++; fifo_lvl -= beat_b; pop_pend = 0; end
            if (rd_pend) begin mem_rvalid = 1'b1; mem_rdata = mem_pat(rd_addr_p); rd_pend = 0; end
            else mem_rvalid = 1'b0;
            mem_gnt = mem_req && gnt_en;
            if (mem_gnt && !mem_we) begin
                rd_pend = 1; rd_addr_p = mem_addr;
                if (rd_n < 64) rd_addr_l[rd_n] = mem_addr;
                rd_n++;
            end
            fifo_rdata = fifo_pat(fifo_idx);
            fifo_level = 8'(fifo_lvl);
            fifo_space = 8'(space_lvl);
            #1;
            if (mem_req) req_n++;
            if (mem_gnt && mem_we) begin
                if (wr_n < 64) begin
                    wr_addr_l[wr_n] = mem_addr; wr_data_l[wr_n] = mem_wdata; wr_size_l[wr_n] = mem_size;
                end
                wr_n++;
                if (!fifo_pop) pop_bad++;
                pop_pend = 1; last_acc = cyc;
            end else if (fifo_pop) pop_bad++;
            if (fifo_push) begin
                if (push_n < 64) push_l[push_n] = fifo_wdata;
                push_n++; last_acc = cyc;
            end
            if (dma_done) begin done_n++; done_cyc = cyc; end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 3'd4;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; #2; d = cfg_rdata;
        cfg_addr = 3'd4;
    endtask

    function automatic bit busy_now();
        return cfg_rdata[1];
    endfunction

    task automatic clear_logs();
        @(negedge clk);
        wr_n = 0; rd_n = 0; push_n = 0; req_n = 0; done_n = 0;
        done_cyc = -1; last_acc = -1; pop_bad = 0; fifo_idx = 0;
    endtask

    task automatic go(input logic [31:0] m, input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] len);
        wr_reg(3'd0, m); wr_reg(3'd1, lo); wr_reg(3'd2, hi); wr_reg(3'd3, len);
        wr_reg(3'd4, 32'd1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk); #2;
            if (!busy_now()) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        #2;
        chk(!mem_req && !dma_done, "R12 outputs idle", {mem_req, dma_done}, 0);
        rd_reg(3'd0, d); chk(d == 0, "R12 mode reset", d, 0);
        rd_reg(3'd4, d); chk(d == 0, "R12 ctrl reset", d, 0);
        rd_reg(3'd5, d); chk(d == 32'h300, "R12 R11 chrst reset", d, 32'h300);
    endtask

    task automatic t_c2m_64();
        logic [63:0] base = 64'h0000_0001_0000_1000;
        clear_logs(); beat_b = 8; fifo_lvl = 32; space_lvl = 0; gnt_en = 1;
        go(32'h0001_0031, 32'h0000_1000, 32'h1, 32'h0002_0010);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(wr_n == 4, "R3 c2m beat count", wr_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk(wr_addr_l[i] == base + 64'(8 * i), "R2 c2m inc addr", wr_addr_l[i], base + 64'(8 * i));
            chk(wr_data_l[i] == fifo_pat(i), "R7 c2m data", wr_data_l[i], fifo_pat(i));
            chk(wr_size_l[i] == 2'd3, "R1 c2m size", wr_size_l[i], 3);
        end
        chk(pop_bad == 0, "R7 pop on grant", pop_bad, 0);
        chk(rd_n == 0 && push_n == 0, "R1 c2m no reads", rd_n + push_n, 0);
        chk(done_n == 1, "R10 one done", done_n, 1);
        chk(done_cyc == last_acc + 1, "R10 done timing", done_cyc, last_acc + 1);
    endtask

    task automatic t_m2c_32();
        clear_logs(); beat_b = 4; fifo_lvl = 0; space_lvl = 64;
        go(32'h0000_0021, 32'h0000_2004, 32'h0, 32'h0003_0004);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(rd_n == 3 && push_n == 3, "R8 m2c beats", push_n, 3);
        for (int i = 0; i < 3; i++) begin
            chk(rd_addr_l[i] == 64'h2004 + 64'(4 * i), "R2 m2c inc addr", rd_addr_l[i], 64'h2004 + 64'(4 * i));
            chk(push_l[i] == (mem_pat(rd_addr_l[i]) & lowmask(4)), "R9 m2c data masked",
                push_l[i], mem_pat(rd_addr_l[i]) & lowmask(4));
        end
        chk(wr_n == 0, "R1 m2c no writes", wr_n, 0);
        chk(done_cyc == last_acc + 1 && done_n == 1, "R10 m2c done", done_cyc, last_acc + 1);
    endtask

    task automatic t_fixed_byte();
        clear_logs(); beat_b = 1; fifo_lvl = 4; space_lvl = 0;
        go(32'h0001_0000, 32'h0000_3003, 32'h0, 32'h0001_0004);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(wr_n == 4, "R3 byte beats", wr_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk(wr_addr_l[i] == 64'h3003, "R2 fixed addr", wr_addr_l[i], 64'h3003);
            chk(wr_data_l[i] == (fifo_pat(i) & lowmask(1)), "R9 byte data", wr_data_l[i], fifo_pat(i) & lowmask(1));
            chk(wr_size_l[i] == 2'd0, "R1 byte size", wr_size_l[i], 0);
        end
    endtask

    task automatic t_gate_c2m();
        clear_logs(); beat_b = 8; fifo_lvl = 4; space_lvl = 0;
        go(32'h0001_0031, 32'h0000_4000, 32'h0, 32'h0001_0008);
        repeat (20) @(negedge clk);
        #2;
        chk(req_n == 0, "R7 no write with partial beat", req_n, 0);
        chk(busy_now(), "R4 busy while waiting", busy_now(), 1);
        fifo_lvl = 8;
        wait_idle();
        repeat (2) @(negedge clk);
        chk(wr_n == 1 && done_n == 1, "R7 write after fill", wr_n, 1);
    endtask

    task automatic t_gate_m2c();
        clear_logs(); beat_b = 4; fifo_lvl = 0; space_lvl = 2;
        go(32'h0000_0021, 32'h0000_5000, 32'h0, 32'h0002_0004);
        repeat (20) @(negedge clk);
        chk(req_n == 0, "R8 no read without room", req_n, 0);
        space_lvl = 64;
        wait_idle();
        repeat (2) @(negedge clk);
        chk(rd_n == 2 && push_n == 2, "R8 reads after room", rd_n, 2);
    endtask

    task automatic t_start_busy();
        logic [31:0] d;
        clear_logs(); beat_b = 8; fifo_lvl = 0; space_lvl = 0;
        go(32'h0001_0031, 32'h0000_6000, 32'h0, 32'h0002_0008);
        rd_reg(3'd4, d);
        chk(d == 32'h2, "R4 ctrl reads busy, start clear", d, 2);
        wr_reg(3'd0, 32'h0001_0000);
        wr_reg(3'd4, 32'd1);
        fifo_lvl = 16;
        wait_idle();
        repeat (2) @(negedge clk);
        chk(wr_n == 2, "R5 second start ignored", wr_n, 2);
        chk(wr_size_l[1] == 2'd3, "R5 latched width kept", wr_size_l[1], 3);
        chk(done_n == 1, "R5 single done", done_n, 1);
    endtask

    task automatic t_invalid();
        clear_logs(); beat_b = 8; fifo_lvl = 64; space_lvl = 64;
        go(32'h0001_0031, 32'h0000_4004, 32'h0, 32'h0001_0008);
        #2; chk(!busy_now(), "R6 misaligned ignored", busy_now(), 0);
        go(32'h0000_0021, 32'h0000_4000, 32'h0, 32'h0000_0004);
        #2; chk(!busy_now(), "R6 zero length ignored", busy_now(), 0);
        go(32'h0000_0021, 32'h0000_4000, 32'h0, 32'h0001_0006);
        #2; chk(!busy_now(), "R6 non-multiple ignored", busy_now(), 0);
        go(32'h0002_0001, 32'h0000_4000, 32'h0, 32'h0001_0004);
        #2; chk(!busy_now(), "R6 reserved dir ignored", busy_now(), 0);
        repeat (4) @(negedge clk);
        chk(req_n == 0 && done_n == 0, "R6 no traffic", req_n + done_n, 0);
        fifo_lvl = 0;
    endtask

    task automatic t_abort();
        logic [31:0] d;
        clear_logs(); beat_b = 8; fifo_lvl = 0; space_lvl = 0;
        go(32'h0000_0031, 32'h0000_7000, 32'h0, 32'h0001_0008);
        #2; chk(busy_now(), "R11 busy before abort", busy_now(), 1);
        wr_reg(3'd5, 32'h200);
        @(negedge clk); #2;
        chk(!busy_now(), "R11 abort clears busy", busy_now(), 0);
        rd_reg(3'd5, d); chk(d == 32'h200, "R11 chrst readback", d, 32'h200);
        space_lvl = 64;
        wr_reg(3'd4, 32'd1);
        repeat (4) @(negedge clk); #2;
        chk(!busy_now() && req_n == 0, "R6 R11 held channel refuses start", req_n, 0);
        chk(done_n == 0, "R11 no done on abort", done_n, 0);
        wr_reg(3'd5, 32'h300);
        wr_reg(3'd4, 32'd1);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(rd_n == 1 && done_n == 1, "R11 channel usable after release", rd_n, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_c2m_64();
        t_m2c_32();
        t_fixed_byte();
        t_gate_c2m();
        t_gate_m2c();
        t_start_busy();
        t_invalid();
        t_abort();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule